// File: doc/BRIEF.md
# Flag-Steered Two's Complement ALU

This block is a purely combinational arithmetic unit for two's complement words. It has no opcode. Six independent one-bit controls shape every result: two of them condition operand A (clear it, then invert it), two condition operand B in the same way, one picks the core function (sum or bitwise AND), and one inverts the core result on the way out. Combining these controls gives derived operations, such as negation, increment, decrement, OR, constants and pass-through, from the same small datapath.

Two status outputs come with every result. One reports a result of all zeros. The other copies the sign bit. The word width is a parameter, 16 bits by default. A surrounding datapath drives the controls directly.

Top module: `flagged_alu`

## Requirements
- R1: When `clr_a` is 1, operand A enters the conditioning stage as zero, whatever `a` holds. With `clr_a`=1, `inv_a`=0, `clr_b`=0, `inv_b`=0 and `sel_sum`=1, `result` equals `b`.
- R2: When `inv_a` is 1, the operand A value coming out of the clear step is inverted bit by bit. For example, `clr_a`=1 and `inv_a`=1 give a conditioned A of all ones.
- R3: Operand B is conditioned by `clr_b` (clear first) and then `inv_b` (invert second), in the same way as operand A.
- R4: When `sel_sum` is 1, the core output is the sum of the two conditioned operands modulo 2^WIDTH. The carry out is dropped.
- R5: When `sel_sum` is 0, the core output is the bitwise AND of the two conditioned operands.
- R6: When `inv_out` is 1, `result` is the bit-by-bit inverse of the core output. Otherwise `result` is the core output unchanged.
- R7: `is_zero` is 1 exactly when every bit of `result` is 0.
- R8: `is_neg` equals the most significant bit of `result`.
- R9: The control pattern (`clr_a`,`inv_a`,`clr_b`,`inv_b`,`sel_sum`,`inv_out`) = (0,0,1,1,1,1) gives the two's complement negation of `a`. For example, `a`=0x0013 gives 0xFFED.
- R10: The control pattern (0,1,1,1,1,1) gives `a` plus one modulo 2^WIDTH. For example, `a`=0xFFFF gives 0x0000 with `is_zero`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Operand A, two's complement |
| b | input | WIDTH | Operand B, two's complement |
| clr_a | input | 1 | Force operand A to zero |
| inv_a | input | 1 | Invert operand A after the clear step |
| clr_b | input | 1 | Force operand B to zero |
| inv_b | input | 1 | Invert operand B after the clear step |
| sel_sum | input | 1 | 1 selects the sum, 0 selects the bitwise AND |
| inv_out | input | 1 | Invert the core output |
| result | output | WIDTH | Final result |
| is_zero | output | 1 | Result is all zeros |
| is_neg | output | 1 | Sign bit of the result |

## Verification
The bench builds the block with WIDTH left at 16. At that width all 64 control patterns can be swept over the signed-range boundaries 0x7FFF and 0x8000, as well as 0, 1 and 0xFFFF. The wrap-around of the sum and of the increment therefore becomes observable, together with the sign flag turning over between the largest positive value and the most negative one. Random operands taken from a fixed seed then cover the rest of the 16-bit space for every pattern.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  // conditioning controls for one operand: clear first, then invert
  typedef struct packed {
    logic clr;
    logic inv;
  } opnd_ctl_t;

  localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/opnd_cond.sv
`timescale 1ns/1ps
module opnd_cond #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0]      din,
  input  alu_pkg::opnd_ctl_t    ctl,
  output logic [WIDTH-1:0]      dout
);
  logic [WIDTH-1:0] cleared;

  always_comb begin
    cleared = ctl.clr ? '0 : din;
    dout    = ctl.inv ? ~cleared : cleared;
  end
endmodule

// File: rtl/core_fn.sv
`timescale 1ns/1ps
module core_fn #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             sel_sum,
  output logic [WIDTH-1:0] core_q
);
  logic [WIDTH:0]   sum_ext;
  logic [WIDTH-1:0] and_q;

  always_comb begin
    sum_ext = {1'b0, opa} + {1'b0, opb};
    and_q   = opa & opb;
    core_q  = sel_sum ? sum_ext[WIDTH-1:0] : and_q;
  end
endmodule

// File: rtl/out_stage.sv
`timescale 1ns/1ps
module out_stage #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] core_q,
  input  logic             inv_out,
  output logic [WIDTH-1:0] result,
  output logic             is_zero,
  output logic             is_neg
);
  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    result  = inv_out ? ~core_q : core_q;
    is_zero = ~|result;
    is_neg  = result[MSB];
  end
endmodule

// File: rtl/flagged_alu.sv
`timescale 1ns/1ps
module flagged_alu #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             clr_a,
  input  logic             inv_a,
  input  logic             clr_b,
  input  logic             inv_b,
  input  logic             sel_sum,
  input  logic             inv_out,
  output logic [WIDTH-1:0] result,
  output logic             is_zero,
  output logic             is_neg
);
  import alu_pkg::*;

  logic [NUM_OPND-1:0][WIDTH-1:0] opnd_raw;
  logic [NUM_OPND-1:0][WIDTH-1:0] opnd_cnd;
  opnd_ctl_t [NUM_OPND-1:0]       opnd_ctl;
  logic [WIDTH-1:0]               core_q;

  always_comb begin
    opnd_raw[0]     = a;
    opnd_raw[1]     = b;
    opnd_ctl[0].clr = clr_a;
    opnd_ctl[0].inv = inv_a;
    opnd_ctl[1].clr = clr_b;
    opnd_ctl[1].inv = inv_b;
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_cond
    opnd_cond #(.WIDTH(WIDTH)) u_cond (
      .din  (opnd_raw[g]),
      .ctl  (opnd_ctl[g]),
      .dout (opnd_cnd[g])
    );
  end

  core_fn #(.WIDTH(WIDTH)) u_core (
    .opa     (opnd_cnd[0]),
    .opb     (opnd_cnd[1]),
    .sel_sum (sel_sum),
    .core_q  (core_q)
  );

  out_stage #(.WIDTH(WIDTH)) u_out (
    .core_q  (core_q),
    .inv_out (inv_out),
    .result  (result),
    .is_zero (is_zero),
    .is_neg  (is_neg)
  );

  // checks across the conditioning, core and output pieces
  always_comb begin
    if (clr_a && !inv_a && !clr_b && !inv_b && sel_sum && !inv_out)
      p_clear_pass_r1: assert (result == b);
    if (clr_a && inv_a && clr_b && !inv_b && sel_sum && !inv_out)
      p_inv_cleared_r2: assert (&result);
    if (!clr_a && !inv_a && clr_b && inv_b && !sel_sum && !inv_out)
      p_and_ones_r3: assert (result == a);
    if (!clr_a && !inv_a && clr_b && !inv_b && !sel_sum)
      p_and_zero_r5: assert (result == (inv_out ? {WIDTH{1'b1}} : '0));
    p_zero_flag_r7: assert (is_zero == (result == '0));
    p_sign_flag_r8: assert (is_neg == result[WIDTH-1]);
    if (!clr_a && !inv_a && clr_b && inv_b && sel_sum && inv_out)
      p_negate_r9: assert (result == WIDTH'(-a));
    if (!clr_a && inv_a && clr_b && inv_b && sel_sum && inv_out)
      p_increment_r10: assert (result == WIDTH'(a + 1'b1));
  end
endmodule

// File: tb/flagged_alu_test.sv
`timescale 1ns/1ps
module flagged_alu_test;
  localparam int unsigned W = 16;

  logic         clk;
  logic [W-1:0] a, b;
  logic [5:0]   ctl; // {clr_a, inv_a, clr_b, inv_b, sel_sum, inv_out}
  logic [W-1:0] result;
  logic         is_zero, is_neg;
  int           n_checks = 0;
  int           n_errors = 0;
  logic         done = 1'b0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  flagged_alu #(.WIDTH(W)) uut (
    .a(a), .b(b),
    .clr_a(ctl[5]), .inv_a(ctl[4]), .clr_b(ctl[3]), .inv_b(ctl[2]),
    .sel_sum(ctl[1]), .inv_out(ctl[0]),
    .result(result), .is_zero(is_zero), .is_neg(is_neg)
  );

  function automatic logic [W-1:0] ref_alu(input logic [W-1:0] xa,
                                            input logic [W-1:0] xb,
                                            input logic [5:0] c);
    logic [W-1:0] pa, pb, q;
    pa = c[5] ? 16'h0000 : xa;
    if (c[4]) pa = ~pa;
    pb = c[3] ? 16'h0000 : xb;
    if (c[2]) pb = ~pb;
    if (c[1]) q = pa + pb;
    else      q = pa & pb;
    if (c[0]) q = ~q;
    return q;
  endfunction

  task automatic expect_eq(input string req, input logic [W-1:0] act,
                           input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h ctl=%b)",
               req, act, exp, a, b, ctl);
    end
  endtask

  task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic [5:0] c);
    @(negedge clk);
    a = xa; b = xb; ctl = c;
    #1;
  endtask

  task automatic check_full(input logic [W-1:0] xa, input logic [W-1:0] xb,
                            input logic [5:0] c);
    logic [W-1:0] e;
    apply(xa, xb, c);
    e = ref_alu(xa, xb, c);
    expect_eq(c[1] ? "R4" : "R5", result, e);
    expect_eq("R7", {15'd0, is_zero}, {15'd0, e == 16'h0000});
    expect_eq("R8", {15'd0, is_neg}, {15'd0, e[15]});
  endtask

  logic [W-1:0] corners [5];

  initial begin
    corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'hFFFF;
    corners[3] = 16'h7FFF; corners[4] = 16'h8000;
    void'($urandom(32'd1207));
    a = '0; b = '0; ctl = '0;

    // first settled state: all controls low, AND of zeros
    apply(16'h0000, 16'h0000, 6'b000000);
    expect_eq("R5", result, 16'h0000);
    expect_eq("R7", {15'd0, is_zero}, 16'd1);

    // R1: clear A then sum passes B
    apply(16'h1234, 16'h0F0F, 6'b100010);
    expect_eq("R1", result, 16'h0F0F);
    // R2: cleared and inverted A is all ones; with B cleared the sum is 0xFFFF
    apply(16'h5A5A, 16'h3C3C, 6'b111010);
    expect_eq("R2", result, 16'hFFFF);
    expect_eq("R8", {15'd0, is_neg}, 16'd1);
    // R3: B cleared and inverted, AND passes A
    apply(16'hBEEF, 16'h1111, 6'b001100);
    expect_eq("R3", result, 16'hBEEF);
    // R3: B inverted without clear
    apply(16'hFFFF, 16'h00F0, 6'b000100);
    expect_eq("R3", result, 16'hFF0F);
    // R4: carry out dropped
    apply(16'h8000, 16'h8000, 6'b000010);
    expect_eq("R4", result, 16'h0000);
    expect_eq("R7", {15'd0, is_zero}, 16'd1);
    // R6: output inversion of an AND
    apply(16'hF0F0, 16'hFF00, 6'b000001);
    expect_eq("R6", result, 16'h0FFF);
    // R9: negation
    apply(16'h0013, 16'h4444, 6'b001111);
    expect_eq("R9", result, 16'hFFED);
    apply(16'h0027, 16'h0000, 6'b001111);
    expect_eq("R9", result, 16'hFFD9);
    apply(16'h8000, 16'h1234, 6'b001111);
    expect_eq("R9", result, 16'h8000);
    // R10: increment, including wrap
    apply(16'h0027, 16'hAAAA, 6'b011111);
    expect_eq("R10", result, 16'h0028);
    apply(16'hFFFF, 16'h0000, 6'b011111);
    expect_eq("R10", result, 16'h0000);
    expect_eq("R7", {15'd0, is_zero}, 16'd1);
    apply(16'h7FFF, 16'h0000, 6'b011111);
    expect_eq("R10", result, 16'h8000);
    expect_eq("R8", {15'd0, is_neg}, 16'd1);

    // every pattern over corner operands
    for (int c = 0; c < 64; c++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          check_full(corners[i], corners[j], 6'(c));

    // every pattern over random operands
    for (int c = 0; c < 64; c++)
      for (int k = 0; k < 20; k++)
        check_full(16'($urandom), 16'($urandom), 6'(c));

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule